// File: doc/BRIEF.md
# Timed Drawbridge Motor Controller

This block runs a single bridge motor from two cooperating timed state machines. A phase machine swings between a "bridge should be down" phase and a "bridge should be up" phase. The length of each phase, in enabled ticks, comes from an input.

A motor machine follows that phase and two limit switches. While the bridge is going up, the motor is driven until the upper switch closes. While the bridge is going down, the motor keeps pushing for a programmable lock interval after the lower switch closes, so the deck seats firmly.

When the phase turns against the motor's current direction, the motor machine drops to idle for one cycle before it reverses. It never drives both directions at once. Each machine times its intervals with its own counter. A counter advances only on cycles where the tick enable is high, and it latches its interval length when the interval begins.

Top module: `bridge_motor_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `target_up` is 0, `motor_state` is 0 (idle) and both motor outputs are 0.
- R2: Interval start:
  - The first cycle after reset starts a down phase (`target_up`=0).
  - Every phase change starts the next phase.
  - A phase ends on the N-th enabled tick after its start cycle. N is `kd` for the down phase and `ku` for the up phase; a length of 0 behaves as 1.
  - At the end of a phase, `target_up` toggles.
- R3: Cycles with `tick_en`=0 do not advance any interval, so `target_up` holds its value on them.
- R4: `kd`, `ku` and `kl` are sampled in the cycle an interval starts. Later changes have no effect until the next interval of that kind.
- R5: From idle (state 0) with `target_up`=1 and `sw_up`=0, the motor enters UP (state 1). `motor_raise` is 1 exactly in state 1.
- R6: In UP, a closed `sw_up` returns the motor to idle on the next cycle.
- R7: From idle with `target_up`=0 and `sw_down`=0, the motor enters DOWN (state 2). `motor_lower` is 1 exactly in states 2 and 3.
- R8: Lock interval:
  - In DOWN, a closed `sw_down` moves the motor to LOCK (state 3) and starts the lock interval.
  - LOCK returns to idle on the N-th enabled tick after entry, where N is `kl` (0 behaves as 1).
- R9: In UP with `target_up`=0, or in DOWN or LOCK with `target_up`=1, the next state is idle.
- R10: `motor_raise` and `motor_lower` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time base enable; one enabled tick per high cycle |
| sw_down | input | 1 | Lower limit switch, 1 = closed |
| sw_up | input | 1 | Upper limit switch, 1 = closed |
| kd | input | 16 | Down phase length in ticks |
| ku | input | 16 | Up phase length in ticks |
| kl | input | 16 | Lock interval length in ticks |
| motor_raise | output | 1 | Drive motor upward |
| motor_lower | output | 1 | Drive motor downward |
| target_up | output | 1 | Current phase, 1 = bridge should be up |
| motor_state | output | 2 | 0 idle, 1 UP, 2 DOWN, 3 LOCK |

## Verification
A wrong phase count shows up on `target_up` as a toggle one or more enabled ticks early or late. A wrong motor transition shows up on `motor_state` and on the raise and lower outputs in the very cycle after the switch or phase event that should have caused it. Both machines are observable at the ports, so the bench compares a model against `target_up`, `motor_state` and both drive outputs on every cycle. A bad lock timer shows as LOCK held for the wrong number of enabled ticks. A missing pass through idle shows as a direct reversal between raise and lower.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_UP   = 2'd1,
    M_DOWN = 2'd2,
    M_LOCK = 2'd3
  } motor_st_e;
endpackage

// File: rtl/bmc_interval_timer.sv
module bmc_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             arm,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, lim_q;
  logic [CNT_W:0]   cnt_p1;
  logic             adv;

  assign cnt_p1 = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign done   = arm & tick & (cnt_p1 >= {1'b0, lim_q});
  assign adv    = arm & tick & (cnt_q != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      lim_q <= limit;
    end else if (adv) begin
      cnt_q <= cnt_p1[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/bmc_target_fsm.sv
module bmc_target_fsm #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] kd,
  input  logic [CNT_W-1:0] ku,
  output logic             phase_up
);
  logic             up_q, up_d;
  logic             pend_q;
  logic             done, start;
  logic [CNT_W-1:0] lim_sel;

  // pend_q marks the first cycle after reset, which starts the down phase
  assign start = pend_q | done;

  always_comb begin
    up_d = up_q;
    if (done) up_d = ~up_q;
  end

  // length for the phase that begins in this cycle
  assign lim_sel = up_d ? ku : kd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      pend_q <= 1'b1;
    end else begin
      up_q   <= up_d;
      pend_q <= 1'b0;
    end
  end

  bmc_interval_timer #(.CNT_W(CNT_W)) phase_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .arm   (~pend_q),
    .tick  (tick),
    .limit (lim_sel),
    .done  (done)
  );

  assign phase_up = up_q;
endmodule

// File: rtl/bmc_motor_fsm.sv
module bmc_motor_fsm
  import bmc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             phase_up,
  input  logic             sw_down,
  input  logic             sw_up,
  input  logic [CNT_W-1:0] kl,
  output motor_st_e        state
);
  motor_st_e st_q, st_d;
  logic      lock_start, lock_done;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      M_IDLE: begin
        if (phase_up && !sw_up)        st_d = M_UP;
        else if (!phase_up && !sw_down) st_d = M_DOWN;
      end
      M_UP: begin
        if (!phase_up || sw_up) st_d = M_IDLE;
      end
      M_DOWN: begin
        if (phase_up)     st_d = M_IDLE;
        else if (sw_down) st_d = M_LOCK;
      end
      M_LOCK: begin
        if (phase_up || lock_done) st_d = M_IDLE;
      end
      default: st_d = M_IDLE;
    endcase
  end

  assign lock_start = (st_q == M_DOWN) && (st_d == M_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= M_IDLE;
    else        st_q <= st_d;
  end

  bmc_interval_timer #(.CNT_W(CNT_W)) lock_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (lock_start),
    .arm   (st_q == M_LOCK),
    .tick  (tick),
    .limit (kl),
    .done  (lock_done)
  );

  assign state = st_q;
endmodule

// File: rtl/bridge_motor_ctrl.sv
module bridge_motor_ctrl
  import bmc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             sw_down,
  input  logic             sw_up,
  input  logic [CNT_W-1:0] kd,
  input  logic [CNT_W-1:0] ku,
  input  logic [CNT_W-1:0] kl,
  output logic             motor_raise,
  output logic             motor_lower,
  output logic             target_up,
  output logic [1:0]       motor_state
);
  logic      phase_up;
  motor_st_e mstate;

  bmc_target_fsm #(.CNT_W(CNT_W)) target_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .kd       (kd),
    .ku       (ku),
    .phase_up (phase_up)
  );

  bmc_motor_fsm #(.CNT_W(CNT_W)) motor_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .phase_up (phase_up),
    .sw_down  (sw_down),
    .sw_up    (sw_up),
    .kl       (kl),
    .state    (mstate)
  );

  assign target_up   = phase_up;
  assign motor_state = mstate;
  assign motor_raise = (mstate == M_UP);
  assign motor_lower = (mstate == M_DOWN) || (mstate == M_LOCK);
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       sw_down,
  input logic       sw_up,
  input logic       motor_raise,
  input logic       motor_lower,
  input logic       target_up,
  input logic [1:0] motor_state
);
  p_drive_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(motor_raise && motor_lower));

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(target_up));

  p_up_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!target_up && motor_state == 2'd1) |=> (motor_state == 2'd0));

  p_down_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (target_up && motor_state[1]) |=> (motor_state == 2'd0));

  p_up_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_state == 2'd1 && sw_up) |=> (motor_state == 2'd0));

  p_lock_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_state == 2'd2 && sw_down && !target_up) |=> (motor_state == 2'd3));

  p_raise_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_state == 2'd0 && target_up && !sw_up) |=> motor_raise);
endmodule

bind bridge_motor_ctrl bmc_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .sw_down     (sw_down),
  .sw_up       (sw_up),
  .motor_raise (motor_raise),
  .motor_lower (motor_lower),
  .target_up   (target_up),
  .motor_state (motor_state)
);

// File: tb/bridge_motor_ctrl_tb_top.sv
`timescale 1ns/1ps
module bridge_motor_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        sw_down, sw_up;
  logic [15:0] kd, ku, kl;
  logic        motor_raise, motor_lower, target_up;
  logic [1:0]  motor_state;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  int m_up, m_pend, m_tcnt, m_tlim, m_ms, m_lcnt, m_llim;
  int pos;
  localparam int TOP = 6;
  string tag;

  always #10 clk = ~clk;

  bridge_motor_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .sw_down(sw_down), .sw_up(sw_up),
    .kd(kd), .ku(ku), .kl(kl),
    .motor_raise(motor_raise), .motor_lower(motor_lower),
    .target_up(target_up), .motor_state(motor_state)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int len_of(input int k);
    return (k == 0) ? 1 : k;
  endfunction

  task automatic model_reset();
    m_up = 0; m_pend = 1; m_tcnt = 0; m_tlim = 0;
    m_ms = 0; m_lcnt = 0; m_llim = 0;
  endtask

  // one clock of the required behaviour, using the inputs seen at the edge
  task automatic model_step();
    int nms;
    bit lstart;
    nms = m_ms; lstart = 0;
    case (m_ms)
      0: if (m_up == 1 && !sw_up) nms = 1;
         else if (m_up == 0 && !sw_down) nms = 2;
      1: if (m_up == 0 || sw_up) nms = 0;
      2: if (m_up == 1) nms = 0;
         else if (sw_down) begin nms = 3; lstart = 1; end
      3: if (m_up == 1) nms = 0;
         else if (tick_en && m_lcnt + 1 >= len_of(m_llim)) nms = 0;
      default: nms = 0;
    endcase
    if (lstart) begin m_lcnt = 0; m_llim = kl; end
    else if (m_ms == 3 && tick_en) m_lcnt++;
    m_ms = nms;
    if (m_pend == 1) begin
      m_pend = 0; m_tcnt = 0; m_tlim = kd;
    end else if (tick_en) begin
      if (m_tcnt + 1 >= len_of(m_tlim)) begin
        m_up = 1 - m_up; m_tcnt = 0;
        m_tlim = m_up ? ku : kd;
      end else m_tcnt++;
    end
  endtask

  task automatic compare_all();
    string mreq;
    chk(tag, "target_up", target_up, m_up);
    case (m_ms)
      1: mreq = "R5";
      2: mreq = "R7";
      3: mreq = "R8";
      default: mreq = "R6";
    endcase
    chk(mreq, "motor_state", motor_state, m_ms);
    chk("R5", "motor_raise", motor_raise, (m_ms == 1));
    chk("R7", "motor_lower", motor_lower, (m_ms >= 2));
    chk("R10", "drive_excl", motor_raise & motor_lower, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    bit last_up;
    int hold;
    seed = $urandom(1234);
    tag = "R2";
    rst_n = 1'b0; tick_en = 1'b0; kd = 16'd4; ku = 16'd4; kl = 16'd2;
    pos = 0; sw_down = 1'b1; sw_up = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
    chk("R1", "target_up in reset", target_up, 0);
    chk("R1", "motor_state in reset", motor_state, 0);
    chk("R1", "outputs in reset", {motor_raise, motor_lower}, 0);
    rst_n = 1'b1;
    #1;
    chk("R1", "state after release", {target_up, motor_state, motor_raise, motor_lower}, 0);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(posedge clk);
      #1 model_step();
      @(negedge clk);
      compare_all();
      // bridge plant follows the motor
      if (motor_raise && pos < TOP) pos++;
      if (motor_lower && pos > 0) pos--;
      sw_down = (pos == 0);
      sw_up   = (pos == TOP);
      if (cyc < 2000) begin
        tag = "R2";
        tick_en = ($urandom % 4) != 0;
        if ($urandom % 50 == 0) begin
          // R4: new lengths apply only to intervals that start later
          kd = 16'($urandom % 21); ku = 16'($urandom % 21); kl = 16'($urandom % 7);
        end
      end else if (cyc < 2200) begin
        tag = "R3";
        tick_en = 1'b0;
        if (cyc == 2000) last_up = target_up;
        else chk("R3", "phase frozen", target_up, last_up);
      end else if (cyc < 3000) begin
        tag = "R2";
        tick_en = 1'b1; kd = 16'd0; ku = 16'd0; kl = 16'd0;
        if (cyc == 2600) begin kd = 16'd9; ku = 16'd9; kl = 16'd3; end
      end else if (cyc < 3500) begin
        tag = "R4";
        tick_en = ($urandom % 2) != 0;
        kd = 16'(1 + $urandom % 3); ku = 16'(1 + $urandom % 3); kl = 16'($urandom % 5);
      end else begin
        tag = "R9";
        tick_en = 1'b1;
        kd = 16'(1 + $urandom % 4); ku = 16'(1 + $urandom % 4); kl = 16'(1 + $urandom % 3);
        sw_down = ($urandom % 3) == 0;
        sw_up   = ($urandom % 3) == 0;
      end
    end

    // directed R8: lock interval length with kl = 5
    rst_n = 1'b0; model_reset();
    tick_en = 1'b0; kd = 16'd200; ku = 16'd200; kl = 16'd5;
    sw_down = 1'b0; sw_up = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1 model_step();      // start cycle; motor goes to DOWN
    @(negedge clk);
    chk("R7", "down entry", motor_state, 2);
    sw_down = 1'b1; tick_en = 1'b1;
    @(posedge clk); #1 model_step();
    @(negedge clk);
    chk("R8", "lock entry", motor_state, 3);
    hold = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1 model_step();
      @(negedge clk);
      if (motor_state == 3) hold++;
    end
    chk("R8", "lock ticks after entry", hold, 4);
    chk("R8", "idle after lock", motor_state, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule